// File: doc/BRIEF.md
# Speculative Thread Load/Store Ordering Checker

This block watches the memory traffic of a small set of thread contexts that run speculatively in a fixed logical order. It finds the case where a younger thread has already read a word and an older thread then writes that same word. The younger thread has consumed a stale value. The checker then orders the younger thread, and every thread behind it, to be thrown away and run again. Whole threads are restarted. No single instruction is recovered on its own.

The logical order is a ring of context IDs. The oldest context is the head and is not speculative. Retiring the head passes that role to the next context on the ring. Each speculative context keeps a small set of word addresses it has read. Every store is compared against the sets of all contexts younger than the storing one. A squash clears the read sets of the squashed contexts. The same squash vector tells the store buffers around the block to drop those contexts' pending writes. A context whose read set is full stalls its loads to new addresses until it is squashed or becomes the head. The surrounding logic may also squash a context directly.

Top module: `specdep_detector`

## Requirements
- R1: After reset, `squash_o` is all zero, `restart_o` is 0 and `head_o` is 0.
- R2: A store from context S to word A, where a context T younger than S has recorded a load of A, sets bit T of `squash_o` and the bits of every context younger than T on the clock edge that follows the store. On that edge `restart_o` is 1 and `restart_tid_o` is T.
- R3: A store does not cause a squash when no younger context has loaded its address earlier. This covers a store that precedes the load and a store from a younger context to a word an older one read.
- R4: The age of context c is (c - `head_o`) mod N_THREADS, where age 0 is the oldest. A `retire_i` pulse advances `head_o` by one, modulo N_THREADS, on the next edge.
- R5: The head context never records loads. A context that becomes head through a retire has its read set cleared. A store never squashes the head unless the head is squashed directly.
- R6: When several contexts are violated in one cycle, the squash starts at the oldest of them.
- R7: Each context records at most LRS_DEPTH distinct words. A load to a new word from a full, non-head context raises `ld_stall_o` in the same cycle and is not recorded. A load to a word that is already recorded never stalls.
- R8: Squashed contexts have their read sets cleared, so later stores to their old addresses cause no squash.
- R9: A load and a store to the same word in the same cycle count as the store coming first. This causes no squash, but the load is recorded.
- R10: `ext_squash_i` with `ext_tid_i` squashes that context and every younger one. If it comes together with a store violation, the squash starts at the older of the two start points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load event this cycle |
| ld_tid_i | input | TID_W | Context issuing the load |
| ld_addr_i | input | ADDR_W | Word address of the load |
| ld_stall_o | output | 1 | Load cannot be recorded; reissue later |
| st_valid_i | input | 1 | Store event this cycle |
| st_tid_i | input | TID_W | Context issuing the store |
| st_addr_i | input | ADDR_W | Word address of the store |
| retire_i | input | 1 | Retire the head context |
| ext_squash_i | input | 1 | Direct squash request |
| ext_tid_i | input | TID_W | First context of the direct squash |
| squash_o | output | N_THREADS | Contexts to discard, one bit per context ID |
| restart_o | output | 1 | Restart request |
| restart_tid_o | output | TID_W | Oldest context to restart |
| head_o | output | TID_W | Current non-speculative context |

## Verification
The bench drives the ring after the head has wrapped past context 0, so a design that compared raw IDs instead of ages would squash the wrong contexts or miss the violation. It raises two violations in one cycle, and a violation together with a direct squash, to catch a start point that is not the oldest. It fills a read set, then stores to the refused address and to a recorded one, which exposes a design that records past capacity or drops real entries. It also stores to words held by contexts that were just squashed or just became head, which exposes read sets that were not cleared.

// File: rtl/specdep_pkg.sv
package specdep_pkg;
  // distance from head along the ring, 0 = oldest
  function automatic int unsigned ring_pos(int unsigned id, int unsigned head, int unsigned n);
    return (id + n - head) % n;
  endfunction
endpackage

// File: rtl/specdep_ldset.sv
module specdep_ldset #(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rec_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              st_hit_o,
  output logic              ld_present_o,
  output logic              full_o
);
  logic [DEPTH-1:0]  vld_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  st_m, ld_m, ins_m;

  always_comb begin
    logic found;
    found = 1'b0;
    ins_m = '0;
    for (int i = 0; i < DEPTH; i++) begin
      st_m[i] = vld_q[i] && (addr_q[i] == st_addr_i);
      ld_m[i] = vld_q[i] && (addr_q[i] == ld_addr_i);
      if (!vld_q[i] && !found) begin
        ins_m[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign st_hit_o     = |st_m;
  assign ld_present_o = |ld_m;
  assign full_o       = &vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) addr_q[i] <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
    end else if (rec_i && !ld_present_o && !full_o) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_m[i]) begin
          vld_q[i]  <= 1'b1;
          addr_q[i] <= ld_addr_i;
        end
      end
    end
  end
endmodule

// File: rtl/specdep_order.sv
module specdep_order #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  output logic [TID_W-1:0] head_o,
  output logic [TID_W-1:0] age_o [N]
);
  import specdep_pkg::*;
  logic [TID_W-1:0] head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       head_q <= '0;
    else if (retire_i) head_q <= (head_q == TID_W'(N-1)) ? '0 : head_q + 1'b1;
  end

  assign head_o = head_q;

  for (genvar t = 0; t < N; t++) begin : g_age
    assign age_o[t] = TID_W'(ring_pos(t, int'(head_q), N));
  end
endmodule

// File: rtl/specdep_squash_sel.sv
module specdep_squash_sel #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic [N-1:0]     cand_i,
  input  logic [TID_W-1:0] age_i [N],
  output logic [N-1:0]     mask_o,
  output logic             any_o,
  output logic [TID_W-1:0] tid_o
);
  logic [TID_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    best  = TID_W'(N-1);
    tid_o = '0;
    for (int t = 0; t < N; t++) begin
      if (cand_i[t] && (!any_o || age_i[t] < best)) begin
        any_o = 1'b1;
        best  = age_i[t];
        tid_o = TID_W'(t);
      end
    end
    for (int t = 0; t < N; t++) mask_o[t] = any_o && (age_i[t] >= best);
  end
endmodule

// File: rtl/specdep_detector.sv
module specdep_detector #(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned ADDR_W    = 30,
  parameter int unsigned LRS_DEPTH = 4,
  localparam int unsigned TID_W    = $clog2(N_THREADS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_valid_i,
  input  logic [TID_W-1:0]     ld_tid_i,
  input  logic [ADDR_W-1:0]    ld_addr_i,
  output logic                 ld_stall_o,
  input  logic                 st_valid_i,
  input  logic [TID_W-1:0]     st_tid_i,
  input  logic [ADDR_W-1:0]    st_addr_i,
  input  logic                 retire_i,
  input  logic                 ext_squash_i,
  input  logic [TID_W-1:0]     ext_tid_i,
  output logic [N_THREADS-1:0] squash_o,
  output logic                 restart_o,
  output logic [TID_W-1:0]     restart_tid_o,
  output logic [TID_W-1:0]     head_o
);
  logic [TID_W-1:0]     age [N_THREADS];
  logic [N_THREADS-1:0] st_hit, ld_present, full, rec, clr, cand, sq_mask;
  logic                 sq_any;
  logic [TID_W-1:0]     sq_tid;

  specdep_order #(.N(N_THREADS), .TID_W(TID_W)) u_order (
    .clk_i, .rst_ni, .retire_i, .head_o, .age_o(age)
  );

  for (genvar t = 0; t < N_THREADS; t++) begin : g_ctx
    // store from an older context that hits this context's reads
    assign cand[t] = (st_valid_i && st_hit[t] && (age[t] > age[st_tid_i]))
                   || (ext_squash_i && ext_tid_i == TID_W'(t));
    assign rec[t]  = ld_valid_i && ld_tid_i == TID_W'(t) && age[t] != '0 && !sq_mask[t];
    assign clr[t]  = sq_mask[t] || (retire_i && age[t] == TID_W'(1));

    specdep_ldset #(.ADDR_W(ADDR_W), .DEPTH(LRS_DEPTH)) u_set (
      .clk_i, .rst_ni,
      .clear_i      (clr[t]),
      .rec_i        (rec[t]),
      .ld_addr_i,
      .st_addr_i,
      .st_hit_o     (st_hit[t]),
      .ld_present_o (ld_present[t]),
      .full_o       (full[t])
    );
  end

  specdep_squash_sel #(.N(N_THREADS), .TID_W(TID_W)) u_sel (
    .cand_i(cand), .age_i(age), .mask_o(sq_mask), .any_o(sq_any), .tid_o(sq_tid)
  );

  assign ld_stall_o = ld_valid_i && age[ld_tid_i] != '0
                   && full[ld_tid_i] && !ld_present[ld_tid_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      squash_o      <= '0;
      restart_o     <= 1'b0;
      restart_tid_o <= '0;
    end else begin
      squash_o      <= sq_mask;
      restart_o     <= sq_any;
      restart_tid_o <= sq_tid;
    end
  end
endmodule

// File: rtl/specdep_detector_chk.sv
module specdep_detector_chk #(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned TID_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ld_valid_i,
  input logic                 ld_stall_o,
  input logic                 st_valid_i,
  input logic                 retire_i,
  input logic                 ext_squash_i,
  input logic [N_THREADS-1:0] squash_o,
  input logic                 restart_o,
  input logic [TID_W-1:0]     restart_tid_o,
  input logic [TID_W-1:0]     head_o
);
  a_r2_restart_iff_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o == (squash_o != '0));

  a_r2_restart_tid_squashed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> squash_o[restart_tid_o]);

  a_r3_no_cause_no_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_valid_i && !ext_squash_i) |=> squash_o == '0);

  a_r4_head_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> head_o == (($past(head_o) == TID_W'(N_THREADS-1)) ? '0 : $past(head_o) + 1'b1));

  a_r4_head_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> $stable(head_o));

  a_r5_head_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_squash_i |=> !squash_o[$past(head_o)]);

  a_r7_stall_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_stall_o |-> ld_valid_i);
endmodule

bind specdep_detector specdep_detector_chk #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_chk (.*);

// File: tb/specdep_detector_tb.sv
`timescale 1ns/1ps
module specdep_detector_tb;
  localparam int N = 4;
  localparam int AW = 30;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0;
  logic ld_v = 0, st_v = 0, ret = 0, exs = 0;
  logic [TW-1:0] ld_t = 0, st_t = 0, ex_t = 0;
  logic [AW-1:0] ld_a = 0, st_a = 0;
  logic ld_stall, restart;
  logic [N-1:0] squash;
  logic [TW-1:0] restart_tid, head;

  always #2 clk = ~clk;

  specdep_detector #(.N_THREADS(N), .ADDR_W(AW), .LRS_DEPTH(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_v), .ld_tid_i(ld_t), .ld_addr_i(ld_a), .ld_stall_o(ld_stall),
    .st_valid_i(st_v), .st_tid_i(st_t), .st_addr_i(st_a),
    .retire_i(ret), .ext_squash_i(exs), .ext_tid_i(ex_t),
    .squash_o(squash), .restart_o(restart), .restart_tid_o(restart_tid), .head_o(head)
  );

  typedef struct { logic [N-1:0] sq; logic [TW-1:0] tid; string tag; } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectation queued for the monitor
  task automatic op(bit lv, int lt, int la, bit sv, int stt, int sa, bit r,
                    bit es, int et, logic [N-1:0] esq, int etid, bit estall, string tag);
    exp_t e;
    @(negedge clk);
    ld_v = lv; ld_t = TW'(lt); ld_a = AW'(la);
    st_v = sv; st_t = TW'(stt); st_a = AW'(sa);
    ret = r; exs = es; ex_t = TW'(et);
    e.sq = esq; e.tid = TW'(etid); e.tag = tag;
    q.push_back(e);
    #1;
    if (lv) chk(ld_stall == estall, tag, "ld_stall_o", int'(ld_stall), int'(estall));
  endtask

  task automatic ld(int t, int a, bit estall, string tag);
    op(1, t, a, 0, 0, 0, 0, 0, 0, '0, 0, estall, tag);
  endtask
  task automatic st(int t, int a, logic [N-1:0] esq, int etid, string tag);
    op(0, 0, 0, 1, t, a, 0, 0, 0, esq, etid, 0, tag);
  endtask
  task automatic idle(string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, '0, 0, 0, tag);
  endtask

  // monitor: compares registered outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(squash == e.sq, e.tag, "squash_o", int'(squash), int'(e.sq));
      chk(restart == (e.sq != '0), e.tag, "restart_o", int'(restart), int'(e.sq != '0));
      if (e.sq != '0) chk(restart_tid == e.tid, e.tag, "restart_tid_o", int'(restart_tid), int'(e.tid));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #10;
    chk(squash == '0, "R1", "squash_o", int'(squash), 0);
    chk(restart == 0, "R1", "restart_o", int'(restart), 0);
    chk(head == 0, "R1", "head_o", int'(head), 0);
    @(negedge clk); rst_n = 1;

    // R2: basic violation, head 0, ages equal ids
    ld(2, 'h10, 0, "R2");
    st(1, 'h10, 4'b1100, 2, "R2");
    // R3: younger store to older read; store before load
    ld(1, 'h20, 0, "R3");
    st(2, 'h20, '0, 0, "R3");
    st(1, 'h30, '0, 0, "R3");
    ld(2, 'h30, 0, "R3");
    // R10: direct squash
    op(0, 0, 0, 0, 0, 0, 0, 1, 1, 4'b1110, 1, 0, "R10");
    // R5/R4: records of new head cleared, head advances
    ld(1, 'h40, 0, "R5");
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, '0, 0, 0, "R4");
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, '0, 0, 0, "R4");
    idle("R4");
    chk(head == 2, "R4", "head_o", int'(head), 2);
    st(2, 'h40, '0, 0, "R5");
    // R4: wrapped ring 2,3,0,1
    ld(0, 'h50, 0, "R4");
    st(3, 'h50, 4'b0011, 0, "R4");
    // R6: two victims, oldest is context 3
    ld(3, 'h60, 0, "R6");
    ld(1, 'h60, 0, "R6");
    st(2, 'h60, 4'b1011, 3, "R6");
    // R7: capacity
    for (int i = 0; i < 4; i++) ld(3, 'h70 + i, 0, "R7");
    ld(3, 'h74, 1, "R7");
    ld(3, 'h71, 0, "R7");
    st(2, 'h74, '0, 0, "R7");
    st(2, 'h72, 4'b1011, 3, "R7");
    // R8: squashed sets are empty
    st(2, 'h71, '0, 0, "R8");
    st(2, 'h60, '0, 0, "R8");
    // R9: same-cycle load and store
    op(1, 3, 'h80, 1, 2, 'h80, 0, 0, 0, '0, 0, 0, "R9");
    st(2, 'h80, 4'b1011, 3, "R9");
    // R10 with R6: violation on 0 plus direct squash from 1
    ld(0, 'h90, 0, "R10");
    op(0, 0, 0, 1, 2, 'h90, 0, 1, 1, 4'b0011, 0, 0, "R10");
    // R5: head load not recorded
    ld(2, 'hA0, 0, "R5");
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, '0, 0, 0, "R5");
    idle("R4");
    chk(head == 3, "R4", "head_o", int'(head), 3);
    st(3, 'hA0, '0, 0, "R5");
    idle("R3");
    idle("R3");
    @(negedge clk);
    chk(q.size() == 0, "R2", "pending", q.size(), 0);
    finish_run();
  end
endmodule